// File: doc/BRIEF.md
# Paged configuration image sequencer

This block sends one of up to eight stored configuration images to a configurable logic target. Each image (a "page") is a region of a flash-like memory whose start address and length are kept in a small option table. A page holds the images for every target in a chain back to back. The sequencer streams the whole page as one run of words, with no gap between one target's image and the next.

A configuration cycle begins when the enable input `cfg_en` rises. On that edge the 3-bit page select is captured, and the select is not looked at again until the next rising edge. The captured page number drives the option-table read port. The block checks the page's length and loads its start address. It then issues one memory read per clock from consecutive addresses. Each returned word is forwarded with a valid flag until the page length is used up. A page with a zero length makes the block fall back to page 0, the fail-safe image, and raise an error flag. Dropping `cfg_en` aborts the cycle at any time. Raising it again with a different page selected reconfigures the target from that page.

The internal sequence is idle, page capture, option fetch, streaming and done. Done is held until `cfg_en` goes low.

Top module: `page_image_seq`

## Requirements
- R1: After reset, `mem_rd_en`, `dout_valid`, `done` and `err_fallback` are all 0 and no read is issued while `cfg_en` stays low.
- R2: `page_sel` is a 3-bit binary page number 0 to 7 with bit 2 the most significant. It is captured only in the clock where `cfg_en` is first seen high after being low. The captured number appears on `opt_idx`. Changes to `page_sel` at any other time, including during streaming, do not alter the page being streamed.
- R3: With `page_sel` tied to 0 the block configures from page 0.
- R4: The page's start address and length come from `opt_start`/`opt_len` for the page shown on `opt_idx`. Reads go to start, start+1, … start+length−1, one address per clock with no gap.
- R5: Exactly length words are flagged by `dout_valid`. Each `dout` is the memory word at the matching address, returned one clock after its read. The first valid word appears in the fourth clock after the edge that samples the rising `cfg_en`.
- R6: If the selected page's length is 0, the block streams page 0 instead and sets `err_fallback`, which holds until the next cycle start. If page 0 also has length 0, no word is sent, `done` rises and `err_fallback` is 1.
- R7: `done` is 1 in the clock carrying the last valid word. It stays 1, with no reads and no valid words, for as long as `cfg_en` stays high. It is 0 one clock after `cfg_en` goes low.
- R8: While `cfg_en` is low no read is issued and `dout_valid` is 0. Dropping it mid-stream aborts the cycle with `done` left at 0.
- R9: After a completed or aborted cycle, a new rising edge of `cfg_en` with a different page selected streams that page in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Cycle enable; rising edge starts, low aborts |
| page_sel | input | SEL_W | Requested page number, MSB first |
| opt_idx | output | SEL_W | Option-table row being read (captured page) |
| opt_start | input | ADDR_W | Start address of row `opt_idx` |
| opt_len | input | LEN_W | Word length of row `opt_idx` |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Memory data, valid one clock after the strobe |
| dout | output | DATA_W | Word forwarded to the target |
| dout_valid | output | 1 | `dout` carries a page word |
| done | output | 1 | Whole page sent; held while `cfg_en` is high |
| err_fallback | output | 1 | Selected page was empty, page 0 used |

## Verification
The properties rely on three things about the inputs. The option table answers combinationally for whatever row `opt_idx` names. The memory returns the word for a strobed address exactly one clock later. No page's start plus length wraps past the top of the address space. The bench keeps to all three. Its table is a combinational array indexed by `opt_idx`, and its memory model registers its word on the strobe edge. All table entries sit well inside the 16-bit space. It changes `cfg_en` and `page_sel` only on falling clock edges, so every capture is a clean single-clock event.

// File: rtl/pis_pkg.sv
package pis_pkg;
   typedef enum logic [2:0] {
      ST_IDLE          = 3'd0,
      ST_LATCH_PAGE    = 3'd1,
      ST_FETCH_OPTIONS = 3'd2,
      ST_STREAM        = 3'd3,
      ST_DONE          = 3'd4
   } pis_state_e;
endpackage

// File: rtl/pis_edge_detect.sv
module pis_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o
);
   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig_i;
   end

   assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pis_ctrl.sv
module pis_ctrl
   import pis_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_en,
   input  logic start_rise,
   input  logic opt_zero,
   input  logic last_word,
   output logic capture,
   output logic fallback,
   output logic empty_fail,
   output logic load_opts,
   output logic rd_en,
   output logic in_done
);
   pis_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (state_q != ST_IDLE && !cfg_en) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:          if (start_rise) state_d = ST_LATCH_PAGE;
            ST_LATCH_PAGE:    state_d = ST_FETCH_OPTIONS;
            ST_FETCH_OPTIONS: state_d = opt_zero ? ST_DONE : ST_STREAM;
            ST_STREAM:        if (last_word) state_d = ST_DONE;
            ST_DONE:          state_d = ST_DONE;
            default:          state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign capture    = (state_q == ST_IDLE) && start_rise;
   assign fallback   = (state_q == ST_LATCH_PAGE) && cfg_en && opt_zero;
   assign empty_fail = (state_q == ST_FETCH_OPTIONS) && cfg_en && opt_zero;
   assign load_opts  = (state_q == ST_FETCH_OPTIONS) && cfg_en && !opt_zero;
   assign rd_en      = (state_q == ST_STREAM) && cfg_en;
   assign in_done    = (state_q == ST_DONE);
endmodule

// File: rtl/pis_page_reg.sv
module pis_page_reg #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             fallback,
   input  logic             empty_fail,
   input  logic [SEL_W-1:0] sel_i,
   output logic [SEL_W-1:0] page_o,
   output logic             err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_o <= '0;
         err_o  <= 1'b0;
      end else begin
         if (capture)       page_o <= sel_i;
         else if (fallback) page_o <= '0;

         if (capture)                     err_o <= 1'b0;
         else if (fallback || empty_fail) err_o <= 1'b1;
      end
   end
endmodule

// File: rtl/pis_addr_gen.sv
module pis_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] start_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

   logic [LEN_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         rem_q  <= '0;
      end else if (load) begin
         addr_o <= start_i;
         rem_q  <= len_i;
      end else if (step) begin
         addr_o <= addr_o + ADDR_ONE;
         rem_q  <= rem_q - LEN_ONE;
      end
   end

   assign last_o = step && (rem_q == LEN_ONE);
endmodule

// File: rtl/page_image_seq.sv
module page_image_seq #(
   parameter int SEL_W   = 3,
   parameter int ADDR_W  = 16,
   parameter int LEN_W   = 16,
   parameter int DATA_W  = 8,
   parameter int OUT_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [SEL_W-1:0]  page_sel,
   output logic [SEL_W-1:0]  opt_idx,
   input  logic [ADDR_W-1:0] opt_start,
   input  logic [LEN_W-1:0]  opt_len,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] dout,
   output logic              dout_valid,
   output logic              done,
   output logic              err_fallback
);
   localparam int NUM_PAGES = 1 << SEL_W;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("page_image_seq: SEL_W out of range");
   end
   if (NUM_PAGES < 2) begin : g_bad_pages
      $error("page_image_seq: need at least two pages");
   end
   if (ADDR_W < 2 || LEN_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("page_image_seq: width parameter too small");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("page_image_seq: OUT_REG must be 0 or 1");
   end

   logic start_rise, opt_zero, last_word;
   logic capture, fallback, empty_fail, load_opts, rd_en, in_done;

   pis_edge_detect u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (cfg_en),
      .rise_o (start_rise)
   );

   assign opt_zero = (opt_len == '0);

   pis_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_en     (cfg_en),
      .start_rise (start_rise),
      .opt_zero   (opt_zero),
      .last_word  (last_word),
      .capture    (capture),
      .fallback   (fallback),
      .empty_fail (empty_fail),
      .load_opts  (load_opts),
      .rd_en      (rd_en),
      .in_done    (in_done)
   );

   pis_page_reg #(.SEL_W(SEL_W)) u_page (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (capture),
      .fallback   (fallback),
      .empty_fail (empty_fail),
      .sel_i      (page_sel),
      .page_o     (opt_idx),
      .err_o      (err_fallback)
   );

   pis_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_opts),
      .step    (rd_en),
      .start_i (opt_start),
      .len_i   (opt_len),
      .addr_o  (mem_addr),
      .last_o  (last_word)
   );

   assign mem_rd_en = rd_en;
   assign done      = in_done;

   logic              rd_q;
   logic              vld_raw;
   logic [DATA_W-1:0] data_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b0;
      else        rd_q <= rd_en;
   end

   if (OUT_REG == 0) begin : g_out_direct
      assign vld_raw  = rd_q;
      assign data_raw = mem_rdata;
   end else begin : g_out_reg
      logic              vld_q;
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
         end else begin
            vld_q  <= rd_q & cfg_en;
            if (rd_q) data_q <= mem_rdata;
         end
      end
      assign vld_raw  = vld_q;
      assign data_raw = data_q;
   end

   assign dout_valid = vld_raw & cfg_en;
   assign dout       = data_raw;
endmodule

// File: rtl/pis_checker.sv
module pis_checker #(
   parameter int SEL_W   = 3,
   parameter int ADDR_W  = 16,
   parameter int OUT_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic [SEL_W-1:0]  opt_idx,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              dout_valid,
   input logic              done,
   input logic              err_fallback
);
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> (!mem_rd_en && !dout_valid)); // R8

   AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R4

   AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |-> $stable(opt_idx)); // R2

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_en) |=> done); // R7

   AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd_en); // R7

   AST_FALLBACK_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
      (err_fallback && mem_rd_en) |-> (opt_idx == '0)); // R6

   if (OUT_REG == 0) begin : g_lat1
      AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
         dout_valid |-> $past(mem_rd_en)); // R5
   end else begin : g_lat2
      AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
         dout_valid |-> $past(mem_rd_en, 2)); // R5
   end
endmodule

bind page_image_seq pis_checker #(
   .SEL_W   (SEL_W),
   .ADDR_W  (ADDR_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_en       (cfg_en),
   .opt_idx      (opt_idx),
   .mem_rd_en    (mem_rd_en),
   .mem_addr     (mem_addr),
   .dout_valid   (dout_valid),
   .done         (done),
   .err_fallback (err_fallback)
);

// File: tb/sim_page_image_seq.sv
`timescale 1ns/1ps
module sim_page_image_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0;
   logic [2:0]  page_sel = 3'd0;
   logic [2:0]  opt_idx;
   logic [15:0] opt_start, opt_len;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = 8'h00;
   logic [7:0]  dout;
   logic        dout_valid, done, err_fallback;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [15:0] tbl_start [8];
   logic [15:0] tbl_len   [8];

   always #10 clk = ~clk;

   page_image_seq u0 (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .page_sel(page_sel),
      .opt_idx(opt_idx), .opt_start(opt_start), .opt_len(opt_len),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .dout(dout), .dout_valid(dout_valid), .done(done), .err_fallback(err_fallback)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign opt_start = tbl_start[opt_idx];
   assign opt_len   = tbl_len[opt_idx];

   always @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

   // {select, expected page, expected error flag, spare}
   localparam logic [7:0] VEC [8] = '{
      {3'd0, 3'd0, 1'b0, 1'b0},
      {3'd1, 3'd1, 1'b0, 1'b0},
      {3'd4, 3'd4, 1'b0, 1'b0},
      {3'd3, 3'd0, 1'b1, 1'b0},
      {3'd7, 3'd7, 1'b0, 1'b0},
      {3'd2, 3'd2, 1'b0, 1'b0},
      {3'd6, 3'd0, 1'b1, 1'b0},
      {3'd5, 3'd5, 1'b0, 1'b0}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_page(input logic [2:0] sel, input logic [2:0] exp_page,
                           input bit exp_err, input int flip_at, input string req);
      int n = 0;
      int bad = 0;
      bit got_done = 1'b0;
      int hold_bad = 0;
      int exp_len = int'(tbl_len[exp_page]);
      logic [15:0] base = tbl_start[exp_page];
      @(negedge clk);
      page_sel = sel;
      cfg_en   = 1'b1;
      for (int c = 0; c < 300 && !got_done; c++) begin
         @(negedge clk);
         if (flip_at > 0 && c == flip_at) page_sel = ~sel;
         if (dout_valid) begin
            if (dout !== memf(base + 16'(n))) bad++;
            n++;
         end
         if (done) got_done = 1'b1;
      end
      check(n == exp_len, req, "valid word count", n, exp_len);
      check(bad == 0, req, "word content mismatches", bad, 0);
      check(got_done, "R7", "done reached", int'(got_done), 1);
      check(err_fallback == exp_err, "R6", "error flag", int'(err_fallback), int'(exp_err));
      for (int h = 0; h < 3; h++) begin
         @(negedge clk);
         if (!done || dout_valid || mem_rd_en) hold_bad++;
      end
      check(hold_bad == 0, "R7", "done hold while enabled", hold_bad, 0);
      cfg_en = 1'b0;
      @(negedge clk);
      check(!done, "R7", "done cleared after enable low", int'(done), 0);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL R5 watchdog expired: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      tbl_start[0] = 16'h0100; tbl_len[0] = 16'd5;
      tbl_start[1] = 16'h0200; tbl_len[1] = 16'd3;
      tbl_start[2] = 16'h0040; tbl_len[2] = 16'd1;
      tbl_start[3] = 16'h0500; tbl_len[3] = 16'd0;
      tbl_start[4] = 16'h0300; tbl_len[4] = 16'd7;
      tbl_start[5] = 16'h0010; tbl_len[5] = 16'd2;
      tbl_start[6] = 16'h0600; tbl_len[6] = 16'd0;
      tbl_start[7] = 16'h07F0; tbl_len[7] = 16'd20;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(!mem_rd_en && !dout_valid && !done && !err_fallback, "R1", "outputs in reset",
            int'({mem_rd_en, dout_valid, done, err_fallback}), 0);
      rst_n = 1'b1;
      begin
         int rd_seen = 0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            page_sel = 3'(i);
            if (mem_rd_en || dout_valid || done) rd_seen++;
         end
         check(rd_seen == 0, "R1", "idle with enable low, select toggling", rd_seen, 0);
      end

      // Vector table walk: R2, R3, R4, R5, R6
      for (int v = 0; v < 8; v++) begin
         run_page(VEC[v][7:5], VEC[v][4:2], VEC[v][1], 0,
                  (VEC[v][7:5] == 3'd0) ? "R3" : "R4");
      end

      // R5 latency: page 2, one word
      begin
         int first = -1;
         @(negedge clk);
         page_sel = 3'd2;
         cfg_en   = 1'b1;
         for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (dout_valid && first < 0) first = k;
         end
         check(first == 4, "R5", "clock of first valid word", first, 4);
         cfg_en = 1'b0;
         repeat (2) @(negedge clk);
      end

      // R2 select change during streaming ignored
      run_page(3'd7, 3'd7, 1'b0, 5, "R2");

      // R8 abort mid-stream, then R9 new page
      begin
         int got = 0;
         int quiet_bad = 0;
         @(negedge clk);
         page_sel = 3'd4;
         cfg_en   = 1'b1;
         for (int c = 0; c < 40 && got < 2; c++) begin
            @(negedge clk);
            if (dout_valid) got++;
         end
         cfg_en = 1'b0;
         for (int q = 0; q < 8; q++) begin
            @(negedge clk);
            if (dout_valid || mem_rd_en || done) quiet_bad++;
         end
         check(quiet_bad == 0, "R8", "activity after abort", quiet_bad, 0);
      end
      run_page(3'd1, 3'd1, 1'b0, 0, "R9");
      run_page(3'd5, 3'd5, 1'b0, 0, "R9");

      // R6 both selected page and page 0 empty
      tbl_len[0] = 16'd0;
      run_page(3'd3, 3'd0, 1'b1, 0, "R6");
      tbl_len[0] = 16'd5;
      // error flag clears on a good cycle
      run_page(3'd1, 3'd1, 1'b0, 0, "R6");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule